// File: doc/BRIEF.md
# Control-Flow-Integrity Register Access Gate

This block owns the two user-level control-flow-integrity registers of a hart: a landing-pad label register and a shadow stack pointer. The CSR unit presents each access to either register here. The request carries the current privilege, the virtualization state, the extension strap, the relevant enable bits from the machine and hypervisor environment-config registers and from the status register, the address, a write strobe and write data. In the same cycle the block decides whether the access is granted. If it is not, it reports either an illegal-instruction fault or a virtual-instruction fault.

A granted access returns the register's current contents on the read-data output. A granted write commits at the next rising clock edge. When the extension strap is tied high and every enable is set, the check collapses to a plain register file of two entries. The layering of the checks is what lets firmware hide the registers from lower privilege levels, and from guests.

Top module: `cfi_csr_gate`

## Requirements
- R1: With `ext_present` low, any valid request to either register address reports fault 2'b01 (illegal instruction), whatever the other inputs are.
- R2: At machine privilege (`priv` = 2'b11) with the extension present, access is always granted (fault 2'b00), whatever the enable bits and `virt` are.
- R3: Below machine privilege (`priv` 2'b00 user or 2'b01 supervisor), a clear `menv_cfi` reports fault 2'b01. This check takes precedence over the hypervisor check.
- R4: Below machine privilege, with `menv_cfi` set, `virt` high and `henv_cfi` clear, the access reports fault 2'b10 (virtual instruction).
- R5: At user privilege, once the checks above pass, access to the label register needs `ufwd_en` and access to the shadow stack pointer needs `ubwd_en`; otherwise fault 2'b01. Supervisor access ignores both bits.
- R6: A granted write to the label register stores only bits [7:0] (lower label), [15:8] (middle label) and [24:16] (upper label) of the write data. Bits [63:25] become zero.
- R7: A granted write to the shadow stack pointer stores all 64 bits, and all 64 bits read back.
- R8: A granted request drives the register's current value on `rdata` in the same cycle. A write updates the register at the next rising edge, so the write cycle itself shows the old value.
- R9: A faulting request leaves both registers unchanged and drives `rdata` to zero.
- R10: With `req_valid` low, or with an address that is neither `LABEL_ADDR` (default 12'h8A0) nor `SSP_ADDR` (default 12'h8A1), `fault` is 2'b00, `rdata` is zero and no register changes.
- R11: After reset both registers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_present | input | 1 | Extension implemented strap |
| priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| virt | input | 1 | Virtualization active |
| menv_cfi | input | 1 | CFI enable from machine environment config |
| henv_cfi | input | 1 | CFI enable from hypervisor environment config |
| ufwd_en | input | 1 | User forward-edge enable from status register |
| ubwd_en | input | 1 | User backward-edge enable from status register |
| req_valid | input | 1 | Access request present |
| req_addr | input | 12 | CSR address |
| req_write | input | 1 | Request writes (high) or only reads (low) |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, zero unless granted |
| fault | output | 2 | 00 none, 01 illegal instruction, 10 virtual instruction |

## Verification
The assertions assume that `priv` never carries the reserved value 2'b10 and that the request inputs are stable over a cycle, since they are sampled at the rising edge. The stimulus draws privilege only from the three legal encodings. It changes inputs only on falling edges. Addresses are drawn from the two register addresses and from one unrelated address, and the enable bits are drawn independently, so every layer of the check is reached with every combination of the other bits.

// File: rtl/cfi_csr_gate.sv
module cfi_csr_gate #(
  parameter int          XLEN       = 64,
  parameter logic [11:0] LABEL_ADDR = 12'h8A0,
  parameter logic [11:0] SSP_ADDR   = 12'h8A1,
  parameter int          LO_W       = 8,
  parameter int          MID_W      = 8,
  parameter int          UP_W       = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_present,
  input  logic [1:0]      priv,
  input  logic            virt,
  input  logic            menv_cfi,
  input  logic            henv_cfi,
  input  logic            ufwd_en,
  input  logic            ubwd_en,
  input  logic            req_valid,
  input  logic [11:0]     req_addr,
  input  logic            req_write,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata,
  output logic [1:0]      fault
);
  localparam int              LABEL_W    = LO_W + MID_W + UP_W;
  localparam logic [XLEN-1:0] LABEL_MASK = {{(XLEN-LABEL_W){1'b0}}, {LABEL_W{1'b1}}};
  localparam logic [1:0]      PRIV_U     = 2'b00;
  localparam logic [1:0]      PRIV_M     = 2'b11;
  localparam logic [1:0]      F_NONE     = 2'b00;
  localparam logic [1:0]      F_ILL      = 2'b01;
  localparam logic [1:0]      F_VIRT     = 2'b10;

  logic [XLEN-1:0] lbl_q, ssp_q;
  logic            hit_lbl, hit_ssp, hit, grant;

  assign hit_lbl = req_valid && (req_addr == LABEL_ADDR);
  assign hit_ssp = req_valid && (req_addr == SSP_ADDR);
  assign hit     = hit_lbl || hit_ssp;

  always_comb begin
    fault = F_NONE;
    if (hit) begin
      if (!ext_present)
        fault = F_ILL;
      else if (priv != PRIV_M) begin
        if (!menv_cfi)
          fault = F_ILL;
        else if (virt && !henv_cfi)
          fault = F_VIRT;
        else if (priv == PRIV_U && ((hit_lbl && !ufwd_en) || (hit_ssp && !ubwd_en)))
          fault = F_ILL;
      end
    end
  end

  assign grant = hit && (fault == F_NONE);
  assign rdata = !grant ? '0 : (hit_lbl ? lbl_q : ssp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lbl_q <= '0;
      ssp_q <= '0;
    end else if (grant && req_write) begin
      if (hit_lbl) lbl_q <= wdata & LABEL_MASK;
      else         ssp_q <= wdata;
    end
  end
endmodule

module cfi_csr_gate_chk #(
  parameter int          XLEN       = 64,
  parameter logic [11:0] LABEL_ADDR = 12'h8A0,
  parameter logic [11:0] SSP_ADDR   = 12'h8A1,
  parameter int          LABEL_W    = 25
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ext_present,
  input logic [1:0]      priv,
  input logic            virt,
  input logic            menv_cfi,
  input logic            henv_cfi,
  input logic            ufwd_en,
  input logic            ubwd_en,
  input logic            req_valid,
  input logic [11:0]     req_addr,
  input logic            req_write,
  input logic [XLEN-1:0] wdata,
  input logic [XLEN-1:0] rdata,
  input logic [1:0]      fault,
  input logic [XLEN-1:0] lbl_q,
  input logic [XLEN-1:0] ssp_q
);
  localparam logic [XLEN-1:0] MASK = {{(XLEN-LABEL_W){1'b0}}, {LABEL_W{1'b1}}};
  logic hl, hs, hit, below_m;
  assign hl      = req_valid && req_addr == LABEL_ADDR;
  assign hs      = req_valid && req_addr == SSP_ADDR;
  assign hit     = hl || hs;
  assign below_m = priv != 2'b11;

  assert_no_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ext_present) |-> fault == 2'b01);
  assert_m_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ext_present && !below_m) |-> fault == 2'b00);
  assert_menv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ext_present && below_m && !menv_cfi) |-> fault == 2'b01);
  assert_henv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ext_present && below_m && menv_cfi && virt && !henv_cfi) |-> fault == 2'b10);
  assert_user_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_present && priv == 2'b00 && menv_cfi && (!virt || henv_cfi)
     && ((hl && !ufwd_en) || (hs && !ubwd_en))) |-> fault == 2'b01);
  assert_label_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hl && req_write && fault == 2'b00) |=> lbl_q == ($past(wdata) & MASK));
  assert_ssp_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && req_write && fault == 2'b00) |=> ssp_q == $past(wdata));
  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault != 2'b00) |=> ($stable(lbl_q) && $stable(ssp_q)));
  assert_fault_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault != 2'b00) |-> rdata == '0);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (fault == 2'b00 && rdata == '0));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(lbl_q) && $stable(ssp_q)));
  assert_code_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault != 2'b11);
endmodule

bind cfi_csr_gate cfi_csr_gate_chk #(
  .XLEN(XLEN), .LABEL_ADDR(LABEL_ADDR), .SSP_ADDR(SSP_ADDR), .LABEL_W(LABEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_present(ext_present), .priv(priv), .virt(virt),
  .menv_cfi(menv_cfi), .henv_cfi(henv_cfi), .ufwd_en(ufwd_en), .ubwd_en(ubwd_en),
  .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write), .wdata(wdata),
  .rdata(rdata), .fault(fault), .lbl_q(lbl_q), .ssp_q(ssp_q)
);

// File: tb/test_cfi_csr_gate.sv
`timescale 1ns/1ps
module test_cfi_csr_gate;
  localparam logic [11:0] A_LBL = 12'h8A0;
  localparam logic [11:0] A_SSP = 12'h8A1;
  localparam logic [11:0] A_OTH = 12'h300;
  localparam logic [63:0] LMASK = 64'h0000_0000_01FF_FFFF;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ext_present = 1'b0, virt = 1'b0, menv_cfi = 1'b0, henv_cfi = 1'b0;
  logic        ufwd_en = 1'b0, ubwd_en = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  priv = 2'b11;
  logic [11:0] req_addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic [1:0]  fault;

  int checks = 0, failures = 0;
  logic [63:0] m_lbl = '0, m_ssp = '0;

  always #10 clk = ~clk;

  cfi_csr_gate i_cfi_csr_gate (
    .clk(clk), .rst_n(rst_n), .ext_present(ext_present), .priv(priv), .virt(virt),
    .menv_cfi(menv_cfi), .henv_cfi(henv_cfi), .ufwd_en(ufwd_en), .ubwd_en(ubwd_en),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .wdata(wdata), .rdata(rdata), .fault(fault)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_fault(output string tag);
    logic hit = req_valid && (req_addr == A_LBL || req_addr == A_SSP);
    tag = "R10";
    if (!hit) return 2'b00;
    if (!ext_present) begin tag = "R1"; return 2'b01; end
    if (priv == 2'b11) begin tag = "R2"; return 2'b00; end
    if (!menv_cfi) begin tag = "R3"; return 2'b01; end
    if (virt && !henv_cfi) begin tag = "R4"; return 2'b10; end
    tag = "R5";
    if (priv == 2'b00 && ((req_addr == A_LBL && !ufwd_en) || (req_addr == A_SSP && !ubwd_en)))
      return 2'b01;
    return 2'b00;
  endfunction

  task automatic access(input logic [1:0] p, input logic v, input logic e, input logic me,
                        input logic he, input logic uf, input logic ub, input logic vld,
                        input logic [11:0] a, input logic w, input logic [63:0] d);
    string tag;
    logic [1:0] ef;
    logic [63:0] er;
    logic ok;
    @(negedge clk);
    priv = p; virt = v; ext_present = e; menv_cfi = me; henv_cfi = he;
    ufwd_en = uf; ubwd_en = ub; req_valid = vld; req_addr = a; req_write = w; wdata = d;
    #1;
    ef = exp_fault(tag);
    ok = vld && (a == A_LBL || a == A_SSP) && ef == 2'b00;
    er = !ok ? 64'd0 : (a == A_LBL ? m_lbl : m_ssp);
    chk({tag, " fault"}, {62'd0, fault}, {62'd0, ef});
    chk(ok ? "R8 rdata" : (ef != 2'b00 ? "R9 rdata" : "R10 rdata"), rdata, er);
    @(posedge clk);
    if (ok && w) begin
      if (a == A_LBL) m_lbl = d & LMASK;
      else            m_ssp = d;
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    #45 rst_n = 1'b1;
    // R11: reset values read back in machine mode
    access(2'b11, 0, 1, 0, 0, 0, 0, 1, A_LBL, 0, '0);
    access(2'b11, 0, 1, 0, 0, 0, 0, 1, A_SSP, 0, '0);
    chk("R11 label reset", m_lbl, 64'd0);
    // R6: label keeps only the three fields
    access(2'b11, 0, 1, 0, 0, 0, 0, 1, A_LBL, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    access(2'b11, 0, 1, 0, 0, 0, 0, 1, A_LBL, 0, '0);
    chk("R6 label masked", rdata, 64'h0000_0000_01FF_FFFF);
    // R7: ssp full width
    access(2'b11, 0, 1, 0, 0, 0, 0, 1, A_SSP, 1, 64'hDEAD_BEEF_0123_4567);
    access(2'b11, 0, 1, 0, 0, 0, 0, 1, A_SSP, 0, '0);
    chk("R7 ssp full", rdata, 64'hDEAD_BEEF_0123_4567);
    // R9: user write with forward enable clear is refused
    access(2'b00, 0, 1, 1, 1, 0, 1, 1, A_LBL, 1, 64'h0000_0000_0000_0055);
    access(2'b11, 0, 1, 0, 0, 0, 0, 1, A_LBL, 0, '0);
    chk("R9 label unchanged", rdata, 64'h0000_0000_01FF_FFFF);
    // R1, R3, R4 directed
    access(2'b11, 0, 0, 1, 1, 1, 1, 1, A_SSP, 1, 64'h1);
    access(2'b01, 1, 1, 0, 0, 1, 1, 1, A_SSP, 0, '0);
    access(2'b01, 1, 1, 1, 0, 1, 1, 1, A_LBL, 0, '0);
    access(2'b01, 0, 1, 1, 0, 0, 0, 1, A_LBL, 1, 64'h0123_4567_89AB_CDEF);
    // R10: unrelated address and idle
    access(2'b11, 0, 1, 1, 1, 1, 1, 1, A_OTH, 1, 64'h5);
    access(2'b11, 0, 1, 1, 1, 1, 1, 0, A_SSP, 1, 64'h6);
    access(2'b11, 0, 1, 0, 0, 0, 0, 1, A_SSP, 0, '0);
    chk("R10 ssp unchanged", rdata, m_ssp);
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] p;
      logic [11:0] a;
      int sel = $urandom_range(0, 2);
      p = (sel == 0) ? 2'b00 : (sel == 1) ? 2'b01 : 2'b11;
      sel = $urandom_range(0, 4);
      a = (sel < 2) ? A_LBL : (sel < 4) ? A_SSP : A_OTH;
      access(p, (p != 2'b11) ? 1'($urandom_range(0, 1)) : 1'b0,
             ($urandom_range(0, 7) != 0), 1'($urandom_range(0, 3) != 0),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             ($urandom_range(0, 9) != 0), a, 1'($urandom_range(0, 1)),
             {$urandom, $urandom});
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule